// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block holds four alarm settings for minute, hour, day of month and weekday. It compares them against the calendar counters that run outside the block, and it raises a sticky alarm flag when the enabled settings agree with the current time. Software writes and reads the settings and a small control/status register through a plain register port: address, data and a write strobe, plus a separate combinational read address. The calendar counters feed the current time in on dedicated inputs. They also give a one-cycle strobe on every clock cycle in which the time has just advanced.

Each alarm field can be left out of the comparison through a disable bit in its top position. With these bits an alarm can fire every hour at a given minute, once a day, once a month or on one weekday. The flag is edge-qualified. It sets only when a time step moves the calendar into a matching state. After software clears it, it stays clear for as long as that match continues. An interrupt request follows the flag, gated by an enable bit in the control/status register.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset each alarm register (minute at 09h, hour at 0Ah, day at 0Bh, weekday at 0Ch) reads 80h. The control/status register at 01h reads 00h, and alarm_flag and irq are 0.
- R2: Each alarm register stores bit 7 as its field-disable bit and a value of 7 bits (minute), 6 bits (hour, day) or 3 bits (weekday). Bits that are not stored read 0, so writing FFh reads back FFh, BFh, BFh and 87h. Register 01h stores bit 1 (interrupt enable) and shows the flag at bit 3. Every other bit, and every unused address, reads 0.
- R3: A field whose disable bit is 1 takes no part in the comparison, whatever the current value of that field.
- R4: On a cycle with tick high, the flag sets if at least one field is enabled, every enabled field equals the current time input, and the comparison on the previous tick did not match. The flag is visible after that clock edge.
- R5: If all four disable bits are 1, the flag never sets.
- R6: The flag holds until a write to 01h with bit 3 at 0 clears it. Writing 1 to bit 3 neither sets nor clears the flag.
- R7: After a clear, a tick that finds the match still true does not set the flag again. It sets again only after a tick that does not match, followed by a tick that matches.
- R8: The comparison runs only on tick cycles. A register write or a change in the time inputs with tick low never sets the flag.
- R9: irq is 1 exactly when the flag is 1 and bit 1 of register 01h is 1.
- R10: If a set event and a clearing write fall in the same cycle, the flag ends up set.
- R11: Minute, hour and day values are compared as raw BCD codes, and the weekday as a 3-bit binary number (0 to 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday, binary |
| tick | input | 1 | One-cycle strobe: time has just incremented |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest states to reach are those where the edge register and the flag disagree. One is a match that persists after a clear, which must not set the flag again. Another is a set event that lands in the same cycle as the clearing write. The vector table holds the time on the alarm minute for several ticks, clears between ticks, then steps away and back. Directed tests then drive tick and the clearing write on the same clock edge, and they load an alarm equal to the held time with tick low to show that no set happens without a strobe.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

  localparam int NUM_FIELDS = 4;
  localparam int FIELD_W    = 7;
  localparam int REG_W      = 8;
  localparam int DIS_BIT    = 7;
  localparam int FLAG_BIT   = 3;
  localparam int AIE_BIT    = 1;

  typedef enum int {
    FLD_MIN  = 0,
    FLD_HOUR = 1,
    FLD_DAY  = 2,
    FLD_WDAY = 3
  } field_e;

  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

  function automatic int field_bits(input int idx);
    case (idx)
      FLD_MIN:  return 7;
      FLD_HOUR: return 6;
      FLD_DAY:  return 6;
      default:  return 3;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] field_mask(input int idx);
    return FIELD_W'((1 << field_bits(idx)) - 1);
  endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int ALM_BASE  = 9,
  parameter int CTRL_ADDR = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  flag_in,
  output field_vec_t            alm_val,
  output logic [NUM_FIELDS-1:0] alm_dis,
  output logic                  aie,
  output logic                  clear_req
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic ctrl_hit_w;
  assign ctrl_hit_w = wr_en && (wr_addr == CTRL_A);
  assign clear_req  = ctrl_hit_w && !wr_data[FLAG_BIT];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALM_BASE + i);
    localparam logic [FIELD_W-1:0] MASK   = field_mask(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alm_dis[i] <= 1'b1;
        alm_val[i] <= '0;
      end else if (wr_en && (wr_addr == MY_ADDR)) begin
        alm_dis[i] <= wr_data[DIS_BIT];
        alm_val[i] <= wr_data[FIELD_W-1:0] & MASK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aie <= 1'b0;
    else if (ctrl_hit_w) aie <= wr_data[AIE_BIT];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_A) begin
      rd_data[FLAG_BIT] = flag_in;
      rd_data[AIE_BIT]  = aie;
    end
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rd_addr == ADDR_W'(ALM_BASE + i)) rd_data = {alm_dis[i], alm_val[i]};
    end
  end

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_match_pkg::*;
(
  input  field_vec_t            alm_val,
  input  logic [NUM_FIELDS-1:0] alm_dis,
  input  field_vec_t            cur_val,
  output logic                  match,
  output logic                  any_en
);

  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    assign fld_ok[i] = alm_dis[i] || (alm_val[i] == cur_val[i]);
  end

  assign any_en = !(&alm_dis);
  assign match  = any_en && (&fld_ok);

endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic clear_req,
  output logic flag,
  output logic match_prev
);

  logic set_evt;
  assign set_evt = tick && match && !match_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_prev <= 1'b0;
    else if (tick) match_prev <= match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (set_evt)   flag <= 1'b1;
    else if (clear_req) flag <= 1'b0;
  end

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int ALM_BASE  = 9,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_day,
  input  logic [2:0]        cur_wday,
  input  logic              tick,
  output logic              alarm_flag,
  output logic              irq
);

  field_vec_t            alm_val;
  field_vec_t            cur_val;
  logic [NUM_FIELDS-1:0] alm_dis;
  logic                  aie;
  logic                  clear_req;
  logic                  match_now;
  logic                  match_prev;
  logic                  any_en;

  assign cur_val[FLD_MIN]  = FIELD_W'(cur_min);
  assign cur_val[FLD_HOUR] = FIELD_W'(cur_hour);
  assign cur_val[FLD_DAY]  = FIELD_W'(cur_day);
  assign cur_val[FLD_WDAY] = FIELD_W'(cur_wday);

  alarm_regfile #(
    .ADDR_W(ADDR_W), .ALM_BASE(ALM_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_in(alarm_flag),
    .alm_val(alm_val), .alm_dis(alm_dis),
    .aie(aie), .clear_req(clear_req)
  );

  alarm_compare u_cmp (
    .alm_val(alm_val), .alm_dis(alm_dis), .cur_val(cur_val),
    .match(match_now), .any_en(any_en)
  );

  alarm_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match(match_now),
    .clear_req(clear_req), .flag(alarm_flag), .match_prev(match_prev)
  );

  assign irq = alarm_flag && aie;

endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker
  import alarm_match_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  alarm_flag,
  input logic                  irq,
  input logic                  clear_req,
  input logic                  match_now,
  input logic                  match_prev,
  input logic [NUM_FIELDS-1:0] alm_dis
);

  AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_now && !match_prev) |=> alarm_flag); // R4

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_now && !match_prev && clear_req) |=> alarm_flag); // R10

  AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&alm_dis) && !alarm_flag) |=> !alarm_flag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clear_req) |=> alarm_flag); // R6

  AST_NO_RESET_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_prev && !alarm_flag) |=> !alarm_flag); // R7

  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick)); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> alarm_flag); // R9

endmodule

bind alarm_match_unit alarm_match_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_flag(alarm_flag),
  .irq(irq), .clear_req(clear_req), .match_now(match_now),
  .match_prev(match_prev), .alm_dis(alm_dis)
);

// File: tb/tb_alarm_match_unit.sv
module tb_alarm_match_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_day = '0;
  logic [2:0] cur_wday = '0;
  logic       tick = 1'b0;
  logic       alarm_flag;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alarm_match_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .cur_wday(cur_wday), .tick(tick), .alarm_flag(alarm_flag), .irq(irq)
  );

  // {min, hour, day, wday, expected flag after tick, clear afterwards}
  // Alarm 12:30, day and weekday disabled.
  localparam int NV = 9;
  localparam logic [33:0] VEC [NV] = '{
    {8'h29, 8'h12, 8'h01, 8'h00, 1'b0, 1'b0},
    {8'h30, 8'h12, 8'h01, 8'h00, 1'b1, 1'b1},
    {8'h30, 8'h12, 8'h01, 8'h00, 1'b0, 1'b0},
    {8'h30, 8'h11, 8'h01, 8'h00, 1'b0, 1'b0},
    {8'h30, 8'h12, 8'h01, 8'h00, 1'b1, 1'b1},
    {8'h31, 8'h12, 8'h01, 8'h00, 1'b0, 1'b0},
    {8'h30, 8'h13, 8'h01, 8'h00, 1'b0, 1'b0},
    {8'h30, 8'h12, 8'h05, 8'h06, 1'b1, 1'b0},
    {8'h31, 8'h12, 8'h05, 8'h06, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic set_time(input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dy, input logic [7:0] w);
    cur_min = m[6:0]; cur_hour = h[5:0]; cur_day = dy[5:0]; cur_wday = w[2:0];
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flag", {7'd0, alarm_flag}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(4'(9 + i), r); check("R1 alarm reg", r, 8'h80);
    end
    rd(4'h1, r); check("R1 ctrl", r, 8'h00);
    rst_n = 1'b1;

    // R2 storage masks
    wr(4'h9, 8'hFF); rd(4'h9, r); check("R2 min", r, 8'hFF);
    wr(4'hA, 8'hFF); rd(4'hA, r); check("R2 hour", r, 8'hBF);
    wr(4'hB, 8'hFF); rd(4'hB, r); check("R2 day", r, 8'hBF);
    wr(4'hC, 8'hFF); rd(4'hC, r); check("R2 wday", r, 8'h87);
    wr(4'h1, 8'hFF); rd(4'h1, r); check("R2/R6 ctrl write ones", r, 8'h02);
    rd(4'h5, r); check("R2 unused addr", r, 8'h00);

    // R5 all fields disabled: ticks never set
    set_time(8'h7F, 8'h3F, 8'h3F, 8'h07);
    pulse_tick(); pulse_tick();
    check("R5 none enabled", {7'd0, alarm_flag}, 8'h00);

    // Table walk: R3 R4 R6 R7
    wr(4'h9, 8'h30); wr(4'hA, 8'h12); wr(4'hB, 8'h80); wr(4'hC, 8'h80);
    wr(4'h1, 8'h02);
    for (int k = 0; k < NV; k++) begin
      logic [33:0] v;
      v = VEC[k];
      @(negedge clk);
      set_time(v[33:26], v[25:18], v[17:10], v[9:2]);
      pulse_tick();
      check("R4/R7/R3 table flag", {7'd0, alarm_flag}, {7'd0, v[1]});
      check("R9 irq follows flag", {7'd0, irq}, {7'd0, v[1]});
      if (v[0]) begin
        wr(4'h1, 8'h0A);
        check("R6 flag kept by bit3=1", {7'd0, alarm_flag}, {7'd0, v[1]});
        wr(4'h1, 8'h02);
        check("R6 cleared", {7'd0, alarm_flag}, 8'h00);
      end
    end

    // R9 interrupt enable gating
    set_time(8'h00, 8'h00, 8'h01, 8'h00); pulse_tick();
    set_time(8'h30, 8'h12, 8'h01, 8'h00); pulse_tick();
    wr(4'h1, 8'h08);
    check("R9 irq masked", {7'd0, irq}, 8'h00);
    rd(4'h1, r); check("R9 ctrl read", r, 8'h08);
    wr(4'h1, 8'h0A);
    check("R9 irq enabled", {7'd0, irq}, 8'h01);
    wr(4'h1, 8'h00);

    // R8 no set without tick: alarm written to match held time
    set_time(8'h45, 8'h07, 8'h01, 8'h00); pulse_tick();
    wr(4'h9, 8'h45); wr(4'hA, 8'h07);
    repeat (3) @(negedge clk);
    check("R8 no tick no set", {7'd0, alarm_flag}, 8'h00);
    set_time(8'h44, 8'h07, 8'h01, 8'h00);
    repeat (2) @(negedge clk);
    set_time(8'h45, 8'h07, 8'h01, 8'h00);
    repeat (2) @(negedge clk);
    check("R8 time change no set", {7'd0, alarm_flag}, 8'h00);
    pulse_tick();
    check("R8 tick sets", {7'd0, alarm_flag}, 8'h01);

    // R10 set and clear in same cycle
    wr(4'h1, 8'h00);
    set_time(8'h46, 8'h07, 8'h01, 8'h00); pulse_tick();
    set_time(8'h45, 8'h07, 8'h01, 8'h00);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 4'h1; wr_data = 8'h00;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R10 set beats clear", {7'd0, alarm_flag}, 8'h01);
    wr(4'h1, 8'h00);

    // R11 weekday binary, hour BCD, others disabled
    wr(4'h9, 8'h80); wr(4'hA, 8'h23); wr(4'hC, 8'h05);
    set_time(8'h00, 8'h23, 8'h01, 8'h04); pulse_tick();
    check("R11 wday mismatch", {7'd0, alarm_flag}, 8'h00);
    set_time(8'h00, 8'h17, 8'h01, 8'h05); pulse_tick();
    check("R11 hour 17h vs 23h", {7'd0, alarm_flag}, 8'h00);
    set_time(8'h00, 8'h23, 8'h01, 8'h05); pulse_tick();
    check("R11 wday and hour match", {7'd0, alarm_flag}, 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule